// File: doc/BRIEF.md
# One-Bit Palette Pixel Expander

This block turns a packed monochrome framebuffer into colour pixels. It takes 32-bit words in which every bit is one pixel and gives out 8-bit colour pixels, four at a time, as a 32-bit word of four byte lanes. A pixel whose bit is 1 takes the colour of palette entry 1, and a pixel whose bit is 0 takes the colour of entry 0. Each input word therefore produces eight output words. The first pixel on screen is the least significant bit, and the output words come in order from the low bits of the input word to the high bits.

Both palette entries are replicated across all four lanes, and each lane chooses between the two replicas with its own bit. A producer supplies input words through a valid/ready handshake, and a consumer drains output words through a second valid/ready handshake. Palette writes go into a pending copy, which can be written at any time. A line-start strobe moves the pending copy into the active palette, so a colour change takes effect only at a scanline boundary and never mixes old and new colours within one line.

Top module: `mono_unpack`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1. Both the pending and the active palette hold the reset colours: entry 0 = 8'h00 and entry 1 = 8'hFF.
- R2: An accepted input word produces exactly eight output words. Output word g (g = 0..7) carries input bits 4g+3 down to 4g, so the least significant group comes first. `outValid` rises in the cycle after the word is accepted.
- R3: In each output word, byte lane k (bits 8k+7:8k) holds the pixel for bit k of the current group. A bit value of 1 selects active entry 1, and a bit value of 0 selects active entry 0.
- R4: A cycle with `palWrEn` high writes `palData` into the pending entry chosen by `palSel` (0 = entry 0, 1 = entry 1). Without a line start, this write does not change the colours on `outData`.
- R5: A cycle with `lineStart` high copies both pending entries into the active palette. A palette write in the same cycle updates only the pending copy, and the active palette takes the value the pending copy held before that write.
- R6: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` stays unchanged. No group is skipped or repeated.
- R7: `inReady` is 1 when no word is held, or when the last group is being taken. With `outReady` held high, back-to-back input words give one output word on every cycle, with no gap.
- R8: An input word offered while `inReady` is 0 is not taken, and it produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Scanline boundary strobe; commits the pending palette |
| palWrEn | input | 1 | Pending palette write enable |
| palSel | input | 1 | Palette entry to write (0 or 1) |
| palData | input | 8 | Colour to write |
| inValid | input | 1 | Input word offered |
| inData | input | 32 | Packed pixel bits, one bit per pixel, LSB first |
| inReady | output | 1 | Input word can be taken |
| outValid | output | 1 | Output word present |
| outData | output | 32 | Four 8-bit pixels, first pixel in the lowest byte |
| outReady | input | 1 | Consumer takes the output word |

## Verification
The embedded assertions watch three properties on every cycle. They check that the active palette changes only on a line-start strobe and then equals the previous pending value. They check that the held word and the group counter freeze under backpressure. They also check that an accepted word is followed by a valid first group. The bench covers what the assertions do not reach. It shows the lane order and group order of the colour values against an independent model, and that pending writes stay invisible until the next line. It also covers the write-and-commit collision, words offered while the block is stalled, and gap-free throughput across word boundaries.

// File: rtl/mono_unpack_pkg.sv
package mono_unpack_pkg;

  // Strobes from the sequencer to the datapath for one cycle.
  typedef struct packed {
    logic loadWord;    // capture a new packed word
    logic shiftGroup;  // move to the next group of the held word
    logic palCommit;   // copy the pending palette into the active palette
  } unpackCtl_t;

endpackage

// File: rtl/mono_unpack_ctrl.sv
module mono_unpack_ctrl
  import mono_unpack_pkg::*;
#(
  parameter int GROUPS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       lineStart,
  output logic       inReady,
  output logic       outValid,
  output unpackCtl_t ctl
);

  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(GROUPS - 1);

  logic             haveWord;
  logic [GRP_W-1:0] grpCnt;
  logic             lastGrp;
  logic             fire;
  logic             accept;

  assign lastGrp  = (grpCnt == LAST_GRP);
  assign fire     = haveWord && outReady;
  assign inReady  = !haveWord || (outReady && lastGrp);
  assign accept   = inValid && inReady;
  assign outValid = haveWord;

  always_comb begin
    ctl            = '0;
    ctl.loadWord   = accept;
    ctl.shiftGroup = fire && !lastGrp;
    ctl.palCommit  = lineStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveWord <= 1'b0;
      grpCnt   <= '0;
    end else if (accept) begin
      haveWord <= 1'b1;
      grpCnt   <= '0;
    end else if (fire && lastGrp) begin
      haveWord <= 1'b0;
      grpCnt   <= '0;
    end else if (fire) begin
      grpCnt   <= grpCnt + 1'b1;
    end
  end

  // R6: a stalled output stays presented and keeps its group position
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(grpCnt)));

  // R7: an idle block is always ready for a word
  a_r7_idle_ready: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  // R2: a taken word is presented from its first group on the next cycle
  a_r2_first_group: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid && grpCnt == '0));

  // R2: the last group drained with no new word leaves the output idle
  a_r2_drain_idle: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && lastGrp && !inValid) |=> !outValid);

  // R8: with a held word that is not on its last group, nothing is taken
  a_r8_no_take: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !lastGrp) |-> !inReady);

endmodule

// File: rtl/mono_unpack_dpath.sv
module mono_unpack_dpath
  import mono_unpack_pkg::*;
#(
  parameter int               IN_W       = 32,
  parameter int               LANES      = 4,
  parameter int               PIX_W      = 8,
  parameter logic [PIX_W-1:0] RST_COLOR0 = '0,
  parameter logic [PIX_W-1:0] RST_COLOR1 = '1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  unpackCtl_t             ctl,
  input  logic [IN_W-1:0]        inData,
  input  logic                   palWrEn,
  input  logic                   palSel,
  input  logic [PIX_W-1:0]       palData,
  output logic [LANES*PIX_W-1:0] outData
);

  logic [IN_W-1:0]  wordReg;
  logic [PIX_W-1:0] pend0, pend1;
  logic [PIX_W-1:0] act0, act1;

  // Held word: the current group always sits in the low LANES bits.
  always_ff @(posedge clk) begin
    if (!rstN)               wordReg <= '0;
    else if (ctl.loadWord)   wordReg <= inData;
    else if (ctl.shiftGroup) wordReg <= wordReg >> LANES;
  end

  // Pending palette: writable on any cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend0 <= RST_COLOR0;
      pend1 <= RST_COLOR1;
    end else if (palWrEn) begin
      if (palSel) pend1 <= palData;
      else        pend0 <= palData;
    end
  end

  // Active palette: changes only at a line boundary, from the pre-write pending value.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      act0 <= RST_COLOR0;
      act1 <= RST_COLOR1;
    end else if (ctl.palCommit) begin
      act0 <= pend0;
      act1 <= pend1;
    end
  end

  // Each lane chooses between the two replicated colours using its own bit.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign outData[lane*PIX_W +: PIX_W] = wordReg[lane] ? act1 : act0;
  end

  // R5: a commit loads the pending values present before the edge
  a_r5_commit_copy: assert property (@(posedge clk) disable iff (!rstN)
    ctl.palCommit |=> (act0 == $past(pend0) && act1 == $past(pend1)));

  // R4: with no line start, the active colours never move
  a_r4_active_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.palCommit |=> ($stable(act0) && $stable(act1)));

  // R6: the held bits do not move without a load or a group advance
  a_r6_word_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadWord && !ctl.shiftGroup) |=> $stable(wordReg));

endmodule

// File: rtl/mono_unpack.sv
module mono_unpack
  import mono_unpack_pkg::*;
#(
  parameter int               IN_W       = 32,
  parameter int               LANES      = 4,
  parameter int               PIX_W      = 8,
  parameter logic [PIX_W-1:0] RST_COLOR0 = 8'h00,
  parameter logic [PIX_W-1:0] RST_COLOR1 = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lineStart,
  input  logic                   palWrEn,
  input  logic                   palSel,
  input  logic [PIX_W-1:0]       palData,
  input  logic                   inValid,
  input  logic [IN_W-1:0]        inData,
  output logic                   inReady,
  output logic                   outValid,
  output logic [LANES*PIX_W-1:0] outData,
  input  logic                   outReady
);

  localparam int GROUPS = IN_W / LANES;

  unpackCtl_t ctl;

  mono_unpack_ctrl #(
    .GROUPS(GROUPS)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .lineStart(lineStart),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  mono_unpack_dpath #(
    .IN_W      (IN_W),
    .LANES     (LANES),
    .PIX_W     (PIX_W),
    .RST_COLOR0(RST_COLOR0),
    .RST_COLOR1(RST_COLOR1)
  ) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .inData (inData),
    .palWrEn(palWrEn),
    .palSel (palSel),
    .palData(palData),
    .outData(outData)
  );

endmodule

// File: tb/sim_mono_unpack.sv
`timescale 1ns/1ps
module sim_mono_unpack;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic        palWrEn = 1'b0;
  logic        palSel = 1'b0;
  logic [7:0]  palData = '0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic        outValid;
  logic [31:0] outData;
  logic        outReady = 1'b1;

  always #4 clk = ~clk;

  mono_unpack u0 (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .palWrEn(palWrEn),
    .palSel(palSel), .palData(palData), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Palette model
  logic [7:0] expAct0 = 8'h00, expAct1 = 8'hFF;
  logic [7:0] expPend0 = 8'h00, expPend1 = 8'hFF;

  // Scoreboard
  logic [31:0] expQ[$];
  string       tagQ[$];

  int readyMode = 0;  // 0 always ready, 1 pattern, 2 held low
  int cyc = 0;
  int firstFire = -1;
  int lastFire = -1;
  int fireCount = 0;
  bit prevStall = 0;
  logic [31:0] prevData = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expand(input logic [3:0] nib, input logic [7:0] c0, input logic [7:0] c1);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = nib[k] ? c1 : c0;
    return r;
  endfunction

  // Driver: called at posedge+1 phase, returns at posedge+1 phase.
  task automatic sendWord(input logic [31:0] w, input string tag);
    bit r;
    for (int g = 0; g < 8; g++) begin
      expQ.push_back(expand(w[4*g +: 4], expAct0, expAct1));
      tagQ.push_back(tag);
    end
    inValid = 1'b1;
    inData  = w;
    forever begin
      @(negedge clk); r = inReady;
      @(posedge clk); #1;
      if (r) break;
    end
    inValid = 1'b0;
  endtask

  task automatic writePal(input bit sel, input logic [7:0] v, input bit alsoStart);
    palWrEn = 1'b1; palSel = sel; palData = v; lineStart = alsoStart;
    @(posedge clk); #1;
    palWrEn = 1'b0; lineStart = 1'b0;
    if (alsoStart) begin expAct0 = expPend0; expAct1 = expPend1; end
    if (sel) expPend1 = v; else expPend0 = v;
  endtask

  task automatic pulseLine();
    lineStart = 1'b1;
    @(posedge clk); #1;
    lineStart = 1'b0;
    expAct0 = expPend0; expAct1 = expPend1;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(posedge clk);
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Ready pattern
  initial forever begin
    @(posedge clk); #1;
    case (readyMode)
      0: outReady = 1'b1;
      1: outReady = (cyc % 3) != 0;
      default: outReady = 1'b0;
    endcase
  end

  // Monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      cyc++;
      if (prevStall)  // R6
        check(outValid && outData == prevData, "R6 stall hold", outData, prevData);
      if (outValid && outReady) begin
        fireCount++;
        if (firstFire < 0) firstFire = cyc;
        lastFire = cyc;
        if (expQ.size() == 0) begin
          check(0, "R8 unexpected output word", outData, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(outData == e, {t, " R2 group order R3 lanes"}, outData, e);
        end
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0 pending", expQ.size());
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", 32'(outValid), 32'h0);
    check(inReady == 1'b1, "R1 inReady after reset", 32'(inReady), 32'h1);
    @(posedge clk); #1;

    // R1 reset colours, R2/R3 mapping
    sendWord(32'h8421_F05A, "R1");
    drain();

    // R4: pending write invisible until line start
    writePal(1'b0, 8'h3C, 1'b0);
    writePal(1'b1, 8'hC3, 1'b0);
    sendWord(32'h1234_5678, "R4");
    drain();

    // R5: commit
    pulseLine();
    sendWord(32'hFFFF_0000, "R5");
    drain();

    // R5: write in the same cycle as the commit
    writePal(1'b1, 8'h99, 1'b0);
    writePal(1'b0, 8'h55, 1'b1);   // active becomes 3C/99, pending 55/99
    sendWord(32'h0F0F_0F0F, "R5");
    drain();
    pulseLine();
    sendWord(32'hDEAD_BEEF, "R5");
    drain();

    // R6: backpressure pattern
    readyMode = 1;
    sendWord(32'hA5A5_5A5A, "R6");
    sendWord(32'h0123_4567, "R6");
    sendWord(32'hFEDC_BA98, "R6");
    drain();

    // R8: offered word ignored while stalled
    readyMode = 2;
    @(posedge clk); #1;
    sendWord(32'hC0DE_1234, "R8");
    inValid = 1'b1; inData = 32'h7777_7777;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(inReady == 1'b0, "R8 inReady while stalled", 32'(inReady), 32'h0);
      @(posedge clk); #1;
    end
    inValid = 1'b0;
    readyMode = 0;
    drain();

    // R7: back-to-back throughput
    firstFire = -1; lastFire = -1; fireCount = 0;
    sendWord(32'h1111_2222, "R7");
    sendWord(32'h3333_4444, "R7");
    sendWord(32'h5555_6666, "R7");
    drain();
    check(fireCount == 24, "R7 output count", 32'(fireCount), 32'd24);
    check(lastFire - firstFire == 23, "R7 no gaps", 32'(lastFire - firstFire), 32'd23);

    repeat (4) @(posedge clk);
    check(expQ.size() == 0, "R2 scoreboard empty", 32'(expQ.size()), 32'h0);
    done = 1;
    summary();
  end

endmodule